// File: doc/BRIEF.md
# Interleaved Dual-Phase PWM Timing Generator

This block is the digital timing core for two synchronous-buck power stages. One shared phase counter, clocked by the system clock, sets the switching period. Each channel compares that phase against its own duty word. The second channel is offset by half a period from the first, so that the two stages draw input current out of phase. Each channel drives a complementary pair of gate commands, one for the high-side switch and one for the low-side switch. A dead-time gap separates every change between them.

In standby the first channel runs at twice the nominal rate and the second channel is held off. A per-channel soft-start limits the applied duty while the ceiling climbs from zero to full scale, and the second channel's ramp finishes in half the time of the first. Overcurrent on the first channel is sampled only once the high-side switch has been on for a blanking interval, and only outside standby. A detected fault is held in a sticky flag.

Top module: `dual_phase_pwm_gen`

## Requirements
- R1: The phase counter wraps every PERIOD clock cycles when standby is low. The default of 400 cycles at 100 MHz gives 250 kHz, so successive high-side rising edges of one channel are PERIOD cycles apart.
- R2: The second channel's period begins PERIOD/2 cycles after the first channel's. With equal duty words, the second high-side output rises PERIOD/2 cycles after the first.
- R3: While standby is high, the phase advances by two per clock, so the first channel's period is PERIOD/2 cycles. Both gate outputs of the second channel stay low.
- R4: A duty word d is read as d phase units out of PERIOD. A value of 0 never raises the high-side output. Any value of PERIOD or more keeps it high for the whole period.
- R5: The high-side and low-side outputs of a channel are never high together. Each rises only after the other has been low for more than DEAD cycles. With 0 < d < PERIOD and both on and off times above DEAD+1, the high-side output is high for d-DEAD-1 cycles per period.
- R6: The overcurrent input is sampled only in a cycle where the first channel's high-side output is high and has already been high for at least BLANK earlier cycles of the same pulse. At the defaults (BLANK = 40 cycles, 400 ns), a pulse of exactly BLANK cycles never samples.
- R7: A sampled overcurrent sets oc_flag, which stays set until reset. No sample is taken while standby is high.
- R8: Each soft-start ceiling restarts from zero on reset or on its start pulse. The ceiling steps up every SS_DIV cycles, by 1 for the first channel and by 2 for the second, and saturates at PERIOD, where the done output goes high. The applied duty is the smaller of the duty word and the ceiling.
- R9: The applied duty of a channel is captured only when that channel's period starts. A duty change in mid-period takes effect from the next period.
- R10: A channel whose enable is low drives both of its gate outputs low.
- R11: During reset all gate outputs, oc_flag and both done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_a | input | DUTY_W | First channel duty word, in phase units |
| duty_b | input | DUTY_W | Second channel duty word, in phase units |
| standby | input | 1 | Standby: first channel at double rate, second channel off |
| en_a | input | 1 | First channel enable |
| en_b | input | 1 | Second channel enable |
| oc_in | input | 1 | Overcurrent comparator result for the first channel |
| ss_start_a | input | 1 | Restart the first channel soft-start ramp |
| ss_start_b | input | 1 | Restart the second channel soft-start ramp |
| hs_a | output | 1 | First channel high-side gate command |
| ls_a | output | 1 | First channel low-side gate command |
| hs_b | output | 1 | Second channel high-side gate command |
| ls_b | output | 1 | Second channel low-side gate command |
| oc_flag | output | 1 | Sticky overcurrent flag |
| ss_done_a | output | 1 | First channel ceiling at full scale |
| ss_done_b | output | 1 | Second channel ceiling at full scale |

## Verification
The end of the blanking window and the high-side turn-off can fall in the same cycle. This happens when the high-side pulse lasts exactly BLANK cycles. The bench provokes it with a duty word of BLANK+DEAD+1 while holding the overcurrent input high, and expects the flag to stay clear. It then raises the duty word by one, which lengthens the pulse by one cycle, and expects the flag to set. A second pairing is the soft-start ceiling changing at a period boundary. The bench judges this by the high-side on-time being held below its unclamped value right after a ramp restart.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    typedef struct packed {
        logic  en;
        word_t duty;
        word_t ceil;
    } ch_req_t;

    function automatic word_t wmin(input word_t a, input word_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic word_t sat_inc(input word_t v, input word_t step, input word_t lim);
        word_t s;
        s = v + step;
        return ((s > lim) || (s < v)) ? lim : s;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int PERIOD = 400
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  standby,
    output word_t tb
);
    localparam word_t LAST = word_t'(PERIOD - 1);

    word_t step;
    word_t nxt;

    always_comb begin
        step = standby ? word_t'(2) : word_t'(1);
        nxt  = tb + step;
        if (nxt > LAST) begin
            nxt = '0;
        end else if (standby) begin
            nxt[0] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tb <= '0;
        else     tb <= nxt;
    end

    // R1
    tb_range_chk: assert property (@(posedge clk) disable iff (rst) tb <= LAST);

    // R1
    tb_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tb == LAST && !standby) |=> (tb == '0));

    // R3
    tb_even_chk: assert property (@(posedge clk) disable iff (rst)
        $past(standby) |-> (tb[0] == 1'b0));

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart
    import pwm_pkg::*;
#(
    parameter int PERIOD = 400,
    parameter int SS_DIV = 4,
    parameter int STEP   = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output word_t ceil_o,
    output logic  done
);
    localparam word_t P_W      = word_t'(PERIOD);
    localparam word_t DIV_LAST = word_t'(SS_DIV - 1);
    localparam word_t STEP_W   = word_t'(STEP);

    word_t div_q;
    word_t ceil_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            ceil_q <= '0;
            div_q  <= '0;
        end else if (ceil_q != P_W) begin
            if (div_q == DIV_LAST) begin
                div_q  <= '0;
                ceil_q <= sat_inc(ceil_q, STEP_W, P_W);
            end else begin
                div_q <= div_q + word_t'(1);
            end
        end
    end

    assign ceil_o = ceil_q;
    assign done   = (ceil_q == P_W);

    // R8
    ceil_bound_chk: assert property (@(posedge clk) disable iff (rst) ceil_q <= P_W);

    // R8
    ceil_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (ceil_q >= $past(ceil_q)));

    // R8
    ceil_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (ceil_q == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int PERIOD = 400,
    parameter int DEAD   = 4,
    parameter int OFFSET = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  word_t   tb,
    input  ch_req_t req,
    output gate_t   gate
);
    localparam word_t P_W   = word_t'(PERIOD);
    localparam word_t OFF_W = word_t'(OFFSET);
    localparam word_t D_W   = word_t'(DEAD);

    word_t sum;
    word_t phase;
    word_t fresh;
    word_t cur;
    word_t dlat;
    logic  at_start;
    logic  pwm_raw;
    word_t hs_idle;
    word_t ls_idle;

    always_comb begin
        sum      = tb + OFF_W;
        phase    = (sum >= P_W) ? (sum - P_W) : sum;
        at_start = (phase == '0);
        fresh    = wmin(req.duty, req.ceil);
        cur      = at_start ? fresh : dlat;
        pwm_raw  = req.en && (phase < cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlat <= '0;
        end else if (at_start) begin
            dlat <= fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate    <= '0;
            hs_idle <= '0;
            ls_idle <= '0;
        end else begin
            gate.hs <= pwm_raw && (ls_idle >= D_W);
            gate.ls <= req.en && !pwm_raw && (hs_idle >= D_W);
            hs_idle <= gate.hs ? '0 : sat_inc(hs_idle, word_t'(1), D_W);
            ls_idle <= gate.ls ? '0 : sat_inc(ls_idle, word_t'(1), D_W);
        end
    end

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate.hs && gate.ls));

    // R5
    ls_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.ls) |-> !$past(gate.hs));

    // R5
    hs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hs) |-> !$past(gate.ls));

    // R10
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !req.en |=> (!gate.hs && !gate.ls));

endmodule

// File: rtl/pwm_ocp_blank.sv
module pwm_ocp_blank
    import pwm_pkg::*;
#(
    parameter int BLANK = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic hs,
    input  logic oc_in,
    input  logic standby,
    output logic flag
);
    localparam word_t B_W = word_t'(BLANK);

    word_t blk;
    logic  sample;

    assign sample = hs && (blk >= B_W) && oc_in && !standby;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk  <= '0;
            flag <= 1'b0;
        end else begin
            blk <= hs ? sat_inc(blk, word_t'(1), B_W) : '0;
            if (sample) flag <= 1'b1;
        end
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

    // R7
    no_standby_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> !$past(standby));

    // R6
    set_needs_hs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(hs) && $past(oc_in)));

endmodule

// File: rtl/dual_phase_pwm_gen.sv
module dual_phase_pwm_gen
    import pwm_pkg::*;
#(
    parameter int PERIOD = 400,
    parameter int DEAD   = 4,
    parameter int BLANK  = 40,
    parameter int SS_DIV = 4,
    parameter int DUTY_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic              standby,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              oc_in,
    input  logic              ss_start_a,
    input  logic              ss_start_b,
    output logic              hs_a,
    output logic              ls_a,
    output logic              hs_b,
    output logic              ls_b,
    output logic              oc_flag,
    output logic              ss_done_a,
    output logic              ss_done_b
);
    localparam int NCH  = 2;
    localparam int HALF = PERIOD / 2;

    word_t   tb;
    logic    en_w     [NCH];
    word_t   duty_w   [NCH];
    logic    start_w  [NCH];
    word_t   ceil_w   [NCH];
    logic    done_w   [NCH];
    ch_req_t req      [NCH];
    gate_t   gate     [NCH];

    assign en_w[0]    = en_a;
    assign en_w[1]    = en_b && !standby;
    assign duty_w[0]  = word_t'(duty_a);
    assign duty_w[1]  = word_t'(duty_b);
    assign start_w[0] = ss_start_a;
    assign start_w[1] = ss_start_b;

    pwm_timebase #(.PERIOD(PERIOD)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .tb      (tb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_softstart #(
            .PERIOD (PERIOD),
            .SS_DIV (SS_DIV),
            .STEP   (i + 1)
        ) u_ss (
            .clk    (clk),
            .rst    (rst),
            .start  (start_w[i]),
            .ceil_o (ceil_w[i]),
            .done   (done_w[i])
        );

        assign req[i] = '{en: en_w[i], duty: duty_w[i], ceil: ceil_w[i]};

        pwm_channel #(
            .PERIOD (PERIOD),
            .DEAD   (DEAD),
            .OFFSET (i * HALF)
        ) u_ch (
            .clk  (clk),
            .rst  (rst),
            .tb   (tb),
            .req  (req[i]),
            .gate (gate[i])
        );
    end

    pwm_ocp_blank #(.BLANK(BLANK)) u_ocp (
        .clk     (clk),
        .rst     (rst),
        .hs      (gate[0].hs),
        .oc_in   (oc_in),
        .standby (standby),
        .flag    (oc_flag)
    );

    assign hs_a      = gate[0].hs;
    assign ls_a      = gate[0].ls;
    assign hs_b      = gate[1].hs;
    assign ls_b      = gate[1].ls;
    assign ss_done_a = done_w[0];
    assign ss_done_b = done_w[1];

    // R3
    b_quiet_standby_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> (!hs_b && !ls_b));

endmodule

// File: tb/dual_phase_pwm_gen_tb.sv
module dual_phase_pwm_gen_tb;

    localparam int PERIOD = 400;
    localparam int DEAD   = 4;
    localparam int BLANK  = 40;
    localparam int DUTY_W = 9;
    localparam int NV     = 8;

    // duty_a, duty_b, standby, expected hs_a cycles, expected hs_b cycles per PERIOD-cycle window
    localparam int VEC [NV][5] = '{
        '{200, 200, 0, 195, 195},
        '{100, 300, 0,  95, 295},
        '{  0, 400, 0,   0, 400},
        '{400,   0, 0, 400,   0},
        '{ 60, 350, 0,  55, 345},
        '{200, 200, 1, 190,   0},
        '{100, 100, 1,  90,   0},
        '{500,  10, 0, 400,   5}
    };

    logic clk = 1'b0;
    logic rst;
    logic [DUTY_W-1:0] duty_a, duty_b;
    logic standby, en_a, en_b, oc_in, ss_start_a, ss_start_b;
    logic hs_a, ls_a, hs_b, ls_b, oc_flag, ss_done_a, ss_done_b;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc_n  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    dual_phase_pwm_gen u_dut (
        .clk(clk), .rst(rst), .duty_a(duty_a), .duty_b(duty_b),
        .standby(standby), .en_a(en_a), .en_b(en_b), .oc_in(oc_in),
        .ss_start_a(ss_start_a), .ss_start_b(ss_start_b),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
        .oc_flag(oc_flag), .ss_done_a(ss_done_a), .ss_done_b(ss_done_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_hs(output int ca, output int cb);
        ca = 0; cb = 0;
        repeat (PERIOD) begin
            @(negedge clk);
            ca += int'(hs_a);
            cb += int'(hs_b);
        end
    endtask

    task automatic wait_rise(input int sel, output int when);
        logic prev;
        logic now;
        prev = sel == 0 ? hs_a : hs_b;
        forever begin
            @(negedge clk);
            now = sel == 0 ? hs_a : hs_b;
            if (now && !prev) break;
            prev = now;
        end
        when = cyc_n;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1700);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ca, cb, t0, t1;
        rst = 1'b1; duty_a = '0; duty_b = '0; standby = 1'b0;
        en_a = 1'b1; en_b = 1'b1; oc_in = 1'b0;
        ss_start_a = 1'b0; ss_start_b = 1'b0;
        idle(3);
        // R11 reset state
        chk({hs_a, ls_a, hs_b, ls_b, oc_flag, ss_done_a, ss_done_b} == 7'b0, "R11",
            int'({hs_a, ls_a, hs_b, ls_b, oc_flag, ss_done_a, ss_done_b}), 0);
        rst = 1'b0;
        idle(2);
        chk(!ss_done_a && !ss_done_b, "R8 ramp starts at zero", int'({ss_done_a, ss_done_b}), 0);
        idle(1700);
        chk(ss_done_a && ss_done_b, "R8 ramp reaches full scale", int'({ss_done_a, ss_done_b}), 3);

        // table: R1 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            duty_a  = DUTY_W'(VEC[v][0]);
            duty_b  = DUTY_W'(VEC[v][1]);
            standby = VEC[v][2] != 0;
            idle(1000);
            count_hs(ca, cb);
            chk(ca == VEC[v][3], $sformatf("R4 R5 vector %0d ch A", v), ca, VEC[v][3]);
            chk(cb == VEC[v][4], $sformatf("R3 R5 vector %0d ch B", v), cb, VEC[v][4]);
        end

        // R1 nominal period
        standby = 1'b0; duty_a = 9'd200; duty_b = 9'd200;
        idle(1000);
        wait_rise(0, t0);
        wait_rise(0, t1);
        chk(t1 - t0 == PERIOD, "R1 period", t1 - t0, PERIOD);
        // R2 half-period offset
        wait_rise(0, t0);
        wait_rise(1, t1);
        chk(t1 - t0 == PERIOD / 2, "R2 phase offset", t1 - t0, PERIOD / 2);
        // R3 standby period
        standby = 1'b1;
        idle(1000);
        wait_rise(0, t0);
        wait_rise(0, t1);
        chk(t1 - t0 == PERIOD / 2, "R3 standby period", t1 - t0, PERIOD / 2);
        count_hs(ca, cb);
        chk(cb == 0 && !ls_b, "R3 channel B off", cb, 0);
        standby = 1'b0;

        // R9 mid-period duty change
        duty_a = 9'd200;
        idle(1000);
        wait_rise(0, t0);
        duty_a = 9'd100;
        ca = 1;
        while (1) begin
            @(negedge clk);
            if (!hs_a) break;
            ca++;
        end
        chk(ca == 195, "R9 current pulse keeps old duty", ca, 195);
        wait_rise(0, t0);
        ca = 1;
        while (1) begin
            @(negedge clk);
            if (!hs_a) break;
            ca++;
        end
        chk(ca == 95, "R9 next pulse uses new duty", ca, 95);

        // R10 disable
        duty_a = 9'd200; duty_b = 9'd200;
        en_a = 1'b0; en_b = 1'b0;
        idle(5);
        ca = 0;
        repeat (PERIOD) begin
            @(negedge clk);
            ca += int'(hs_a) + int'(ls_a) + int'(hs_b) + int'(ls_b);
        end
        chk(ca == 0, "R10 disabled outputs low", ca, 0);
        en_a = 1'b1; en_b = 1'b1;

        // R6 pulse exactly BLANK cycles long: never sampled
        do_reset();
        duty_a = 9'(BLANK + DEAD + 1);
        idle(1000);
        oc_in = 1'b1;
        idle(1200);
        chk(!oc_flag, "R6 blanking covers whole pulse", int'(oc_flag), 0);
        // R6 one cycle longer: sampled
        duty_a = 9'(BLANK + DEAD + 2);
        idle(1000);
        chk(oc_flag, "R6 sample after blanking", int'(oc_flag), 1);
        // R7 sticky
        oc_in = 1'b0; duty_a = 9'd200;
        idle(900);
        chk(oc_flag, "R7 flag sticky", int'(oc_flag), 1);

        // R7 no sampling in standby
        do_reset();
        standby = 1'b1; duty_a = 9'd200;
        idle(200);
        oc_in = 1'b1;
        idle(1000);
        chk(!oc_flag, "R7 standby ignores overcurrent", int'(oc_flag), 0);
        // R6 no sampling while high side is off
        oc_in = 1'b0; standby = 1'b0;
        do_reset();
        duty_a = 9'd0;
        idle(500);
        oc_in = 1'b1;
        idle(1000);
        chk(!oc_flag, "R6 no sample with high side off", int'(oc_flag), 0);
        oc_in = 1'b0;

        // R8 soft-start restart, ceiling limit and relative speed
        duty_a = 9'd200; duty_b = 9'd200;
        idle(1000);
        ss_start_a = 1'b1; ss_start_b = 1'b1;
        @(negedge clk);
        ss_start_a = 1'b0; ss_start_b = 1'b0;
        @(negedge clk);
        chk(!ss_done_a && !ss_done_b, "R8 restart clears done", int'({ss_done_a, ss_done_b}), 0);
        count_hs(ca, cb);
        chk(ca < 195, "R8 ceiling limits duty", ca, 194);
        idle(800);
        chk(ss_done_b && !ss_done_a, "R8 channel B ramp twice as fast", int'({ss_done_a, ss_done_b}), 1);
        idle(800);
        chk(ss_done_a && ss_done_b, "R8 both ramps done", int'({ss_done_a, ss_done_b}), 3);

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule